// File: doc/BRIEF.md
# Radix-2 Redundant-Digit Square Root Unit

This block computes the square root of a normalized fixed-point radicand. It works one step at a time and produces one signed root digit from {-1, 0, +1} per clock. The partial remainder is kept as two vectors, a partial sum and a carry, so that no step needs a full-width carry chain. The next digit is picked from a short estimate formed from the top few bits of those two vectors. When the estimate lies in a band around zero the digit is 0, and the remainder is just shifted.

The converged root is built on the fly in two registers: the current root Q and Q minus one unit in the last place. The term subtracted or added for a +1 or -1 digit is formed by appending a fixed bit pattern to one of these registers, with no carry propagation. After the last digit, one cycle adds the remainder vectors together. If the result is negative, that cycle takes the root from the Q-minus-one register and corrects the remainder. The outputs are the truncated root and the exact non-negative remainder.

A user pulses `start` with a radicand while the unit is idle. The user then waits for the one-cycle `done` pulse and reads `root` and `remainder`, which hold until the next result.

Top module: `sqrt_rdx2_unit`

## Requirements
- R1: While reset is high, and in the cycle after, `busy`, `done`, `root` and `remainder` are all zero.
- R2: A `start` sampled while idle raises `busy` at that edge. `done` is high for exactly one cycle, starting ROOT_W+1 clock edges after the start edge. `busy` falls at the same edge, so the two are never high together.
- R3: A `start` that arrives while `busy` is high is ignored, together with its radicand. The result still belongs to the accepted radicand, and the completion time does not change.
- R4: The radicand code x lies in [2^(ROOT_W-2), 2^ROOT_W) and stands for X = x/2^ROOT_W. The root code r satisfies r^2 <= x*2^ROOT_W < (r+1)^2, which means Q = r/2^ROOT_W is X's square root truncated to ROOT_W fraction bits.
- R5: `remainder` equals x*2^ROOT_W - r^2. It is never negative, and it fits in ROOT_W+2 bits.
- R6: The most significant bit of `root` is 1 for every legal radicand.
- R7: With ROOT_W = 7 and x = 61, the digit recurrence converges to 89/128 with X - Q^2 = -113/2^14. The correction step must deliver root 88 and remainder 64.
- R8: Between two `done` pulses, `root` and `remainder` keep the previous result. This includes the whole time `busy` is high.
- R9: The smallest radicand, x = 2^(ROOT_W-2), gives root 2^(ROOT_W-1) and remainder 0.
- R10: The largest radicand, x = 2^ROOT_W - 1, gives root 2^ROOT_W - 1 and remainder 2^ROOT_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation on `radicand` when idle |
| radicand | input | ROOT_W | Radicand code x, value x/2^ROOT_W |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| root | output | ROOT_W | Truncated root code r, value r/2^ROOT_W |
| remainder | output | ROOT_W+2 | x*2^ROOT_W - r^2 |

## Verification
The bench builds two instances. One uses the default of 8 root bits. The other uses 7 root bits, which makes the known 61/128 case, where the recurrence overshoots, directly checkable. For both widths, every legal radicand is driven, so each digit path and each case where the final correction is or is not taken is reached exhaustively. That includes the all-zero-digit path at the lowest radicand and the largest root at the top code. On the 8-bit instance, start pulses are also injected mid-run and on the cycle `done` is high. These cover the ignore rule and back-to-back issue.

// File: rtl/sqrt_rdx2_pkg.sv
package sqrt_rdx2_pkg;
  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_NEG  = 2'b10
  } digit_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } state_t;
endpackage

// File: rtl/sqrt_digit_sel.sv
// Coarse digit choice from the truncated top bits of 2*(sum + carry).
module sqrt_digit_sel
  import sqrt_rdx2_pkg::*;
#(
  parameter int REM_W    = 12,
  parameter int EST_INT  = 4,
  parameter int EST_FRAC = 2
) (
  input  logic [REM_W-1:0] sum_i,
  input  logic [REM_W-1:0] carry_i,
  output digit_t           dig_o
);
  localparam int EST_W = EST_INT + EST_FRAC;
  localparam logic signed [EST_W-1:0] HALF     = EST_W'(1 << (EST_FRAC - 1));
  localparam logic signed [EST_W-1:0] NEG_HALF = -HALF;

  logic signed [EST_W-1:0] est;

  // bits [REM_W-2 -: EST_W] of each vector are the top bits of the doubled value
  always_comb begin
    est = $signed(sum_i[REM_W-2 -: EST_W]) + $signed(carry_i[REM_W-2 -: EST_W]);
    if (est >= HALF)          dig_o = DIG_POS;
    else if (est < NEG_HALF)  dig_o = DIG_NEG;
    else                      dig_o = DIG_ZERO;
  end
endmodule

// File: rtl/sqrt_root_regs.sv
// On-the-fly root registers (Q and Q-ulp) and carry-free subtrahend forming.
module sqrt_root_regs
  import sqrt_rdx2_pkg::*;
#(
  parameter int ROOT_W = 8,
  parameter int REM_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_en_i,
  input  digit_t            dig_i,
  input  logic [ROOT_W-1:0] mask_i,
  output logic [ROOT_W:0]   q_o,
  output logic [ROOT_W:0]   qm_o,
  output logic [REM_W-1:0]  addend_o,
  output logic              cin_o
);
  localparam int QW = ROOT_W + 1;

  logic [QW-1:0]    q_r, qm_r;
  logic [QW-1:0]    mask_q;
  logic [REM_W-1:0] mask_r, pos_term, neg_term;

  assign mask_q = QW'(mask_i);
  assign mask_r = REM_W'(mask_i);

  // +1: subtract 2Q + u ; -1: add 2(Q-ulp) + 3u  (bit patterns appended, no carries)
  always_comb begin
    pos_term = REM_W'({q_r, 1'b0}) | mask_r;
    neg_term = REM_W'({qm_r, 1'b0}) | mask_r | (mask_r << 1);
    case (dig_i)
      DIG_POS: begin addend_o = ~pos_term; cin_o = 1'b1; end
      DIG_NEG: begin addend_o = neg_term;  cin_o = 1'b0; end
      default: begin addend_o = '0;        cin_o = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      q_r  <= '0;
      qm_r <= '0;
    end else if (step_en_i) begin
      case (dig_i)
        DIG_POS: begin q_r <= q_r | mask_q;  qm_r <= q_r;           end
        DIG_NEG: begin q_r <= qm_r | mask_q; qm_r <= qm_r;          end
        default: begin q_r <= q_r;           qm_r <= qm_r | mask_q; end
      endcase
    end
  end

  assign q_o  = q_r;
  assign qm_o = qm_r;

  // R4
  q_gap_chk: assert property (@(posedge clk) disable iff (rst)
    step_en_i |=> (q_r - qm_r) == $past(mask_q));
endmodule

// File: rtl/sqrt_rem_csa.sv
// Partial remainder held as sum and carry vectors; one 3:2 compression per step.
module sqrt_rem_csa #(
  parameter int ROOT_W = 8,
  parameter int REM_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ROOT_W-1:0] rad_i,
  input  logic              step_en_i,
  input  logic [REM_W-1:0]  addend_i,
  input  logic              cin_i,
  output logic [REM_W-1:0]  sum_o,
  output logic [REM_W-1:0]  carry_o
);
  logic [REM_W-1:0] s_r, c_r, dbl_s, dbl_c, nxt_s, maj;

  always_comb begin
    dbl_s = s_r << 1;
    dbl_c = c_r << 1;
    nxt_s = dbl_s ^ dbl_c ^ addend_i;
    maj   = (dbl_s & dbl_c) | (dbl_s & addend_i) | (dbl_c & addend_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_r <= '0;
      c_r <= '0;
    end else if (load_i) begin
      s_r <= REM_W'(rad_i);
      c_r <= '0;
    end else if (step_en_i) begin
      s_r <= nxt_s;
      c_r <= {maj[REM_W-2:0], cin_i};
    end
  end

  assign sum_o   = s_r;
  assign carry_o = c_r;

  // R5
  csa_value_chk: assert property (@(posedge clk) disable iff (rst)
    step_en_i |=> (s_r + c_r) ==
      REM_W'(($past(s_r) + $past(c_r)) * 2 + $past(addend_i) + REM_W'($past(cin_i))));
endmodule

// File: rtl/sqrt_rdx2_unit.sv
module sqrt_rdx2_unit
  import sqrt_rdx2_pkg::*;
#(
  parameter int ROOT_W   = 8,
  parameter int EST_INT  = 4,
  parameter int EST_FRAC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ROOT_W-1:0] radicand,
  output logic              busy,
  output logic              done,
  output logic [ROOT_W-1:0] root,
  output logic [ROOT_W+1:0] remainder
);
  localparam int REM_W = EST_INT + ROOT_W;
  localparam int QW    = ROOT_W + 1;

  state_t            state;
  logic [ROOT_W-1:0] mask;
  logic              load, step_en, cin;
  digit_t            dig;
  logic [QW-1:0]     q, qm, fin_root;
  logic [REM_W-1:0]  sum_v, carry_v, addend, rsum, fin_rem;

  assign load    = (state == ST_IDLE) && start;
  assign step_en = (state == ST_RUN);

  sqrt_digit_sel #(.REM_W(REM_W), .EST_INT(EST_INT), .EST_FRAC(EST_FRAC)) u_sel (
    .sum_i(sum_v), .carry_i(carry_v), .dig_o(dig)
  );

  sqrt_root_regs #(.ROOT_W(ROOT_W), .REM_W(REM_W)) u_root (
    .clk(clk), .rst(rst), .load_i(load), .step_en_i(step_en), .dig_i(dig),
    .mask_i(mask), .q_o(q), .qm_o(qm), .addend_o(addend), .cin_o(cin)
  );

  sqrt_rem_csa #(.ROOT_W(ROOT_W), .REM_W(REM_W)) u_rem (
    .clk(clk), .rst(rst), .load_i(load), .rad_i(radicand), .step_en_i(step_en),
    .addend_i(addend), .cin_i(cin), .sum_o(sum_v), .carry_o(carry_v)
  );

  // final assimilation and one-step correction
  always_comb begin
    rsum = sum_v + carry_v;
    if (rsum[REM_W-1]) begin
      fin_root = qm;
      fin_rem  = rsum + REM_W'({q, 1'b0}) - REM_W'(1);
    end else begin
      fin_root = q;
      fin_rem  = rsum;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mask      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      root      <= '0;
      remainder <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          busy  <= 1'b1;
          mask  <= ROOT_W'(1) << (ROOT_W - 1);
        end
        ST_RUN: begin
          mask <= mask >> 1;
          if (mask[0]) state <= ST_FIX;
        end
        ST_FIX: begin
          root      <= fin_root[ROOT_W-1:0];
          remainder <= fin_rem[ROOT_W+1:0];
          done      <= 1'b1;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done));
  // R3
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state == ST_RUN) |=> busy);
  // R5
  rem_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIX) |-> (fin_rem >> (ROOT_W + 2)) == '0);
  // R6
  root_norm_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIX) |-> (fin_root[ROOT_W] == 1'b0 && fin_root[ROOT_W-1] == 1'b1));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && state != ST_FIX) |=> ($stable(root) && $stable(remainder)));
endmodule

// File: tb/tb_sqrt_rdx2_unit.sv
`timescale 1ns/1ps
module tb_sqrt_rdx2_unit;
  localparam int N  = 8;
  localparam int N7 = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, start7 = 1'b0;
  logic [N-1:0]  rad = '0;
  logic [N7-1:0] rad7 = '0;
  logic busy, done, busy7, done7;
  logic [N-1:0]  root;
  logic [N+1:0]  remainder;
  logic [N7-1:0] root7;
  logic [N7+1:0] remainder7;

  always #10 clk = ~clk;

  sqrt_rdx2_unit #(.ROOT_W(N)) dut (
    .clk(clk), .rst(rst), .start(start), .radicand(rad),
    .busy(busy), .done(done), .root(root), .remainder(remainder));

  sqrt_rdx2_unit #(.ROOT_W(N7)) dut7 (
    .clk(clk), .rst(rst), .start(start7), .radicand(rad7),
    .busy(busy7), .done(done7), .root(root7), .remainder(remainder7));

  int checks = 0, fails = 0;
  bit finished = 0, mon_on = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint v);
    longint r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  // behavioural cycle model of the 8-bit instance
  bit     m_busy = 0, m_done = 0;
  int     m_cnt = 0, m_x = 0;
  longint m_root = 0, m_rem = 0;

  always @(posedge clk) begin
    longint xs;
    m_done = 0;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_root = 0; m_rem = 0;
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; m_done = 1;
        xs = longint'(m_x) << N;
        m_root = isqrt(xs);
        m_rem  = xs - m_root * m_root;
      end
    end else if (start) begin
      m_busy = 1; m_cnt = N + 1; m_x = int'(rad);
    end
    mon_on = 1;
  end

  always @(negedge clk) begin
    longint xs, r;
    if (mon_on && !finished) begin
      chk(busy == m_busy, "R2", "busy", longint'(busy), longint'(m_busy));
      chk(done == m_done, "R2", "done", longint'(done), longint'(m_done));
      chk(longint'(root) == m_root, m_done ? "R4" : "R8", "root", longint'(root), m_root);
      chk(longint'(remainder) == m_rem, m_done ? "R5" : "R8", "remainder",
          longint'(remainder), m_rem);
      if (done && m_done) begin
        xs = longint'(m_x) << N;
        r  = longint'(root);
        chk(r * r <= xs && xs < (r + 1) * (r + 1), "R4", "root bracket", r, isqrt(xs));
        chk(root[N-1] == 1'b1, "R6", "root msb", longint'(root[N-1]), 1);
      end
    end
  end

  initial begin
    longint xs, er;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "busy/done in reset", longint'({busy, done}), 0);
    chk(root == 0 && remainder == 0, "R1", "outputs in reset", longint'(root), 0);
    chk(busy7 == 0 && root7 == 0 && remainder7 == 0, "R1", "second instance in reset",
        longint'(root7), 0);
    rst = 1'b0;

    // exhaustive 8-bit run with mid-run and back-to-back start pulses
    for (int x = 2 ** (N - 2); x < 2 ** N; x++) begin
      while (busy) @(negedge clk);
      start = 1'b1; rad = N'(x);
      @(negedge clk);
      start = 1'b0; rad = ~N'(x);
      if (x % 3 == 0) begin
        repeat (3) @(negedge clk);
        start = 1'b1; rad = N'(x) ^ 8'h5A;   // R3: must be ignored
        @(negedge clk);
        start = 1'b0;
      end
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);

    // exhaustive 7-bit run with the named corner cases
    for (int x = 2 ** (N7 - 2); x < 2 ** N7; x++) begin
      start7 = 1'b1; rad7 = N7'(x);
      @(negedge clk);
      start7 = 1'b0;
      while (!done7) @(negedge clk);
      xs = longint'(x) << N7;
      er = isqrt(xs);
      chk(longint'(root7) == er, "R4", "root7", longint'(root7), er);
      chk(longint'(remainder7) == xs - er * er, "R5", "remainder7",
          longint'(remainder7), xs - er * er);
      chk(root7[N7-1] == 1'b1, "R6", "root7 msb", longint'(root7[N7-1]), 1);
      if (x == 61) begin
        chk(root7 == 88, "R7", "example root", longint'(root7), 88);
        chk(remainder7 == 64, "R7", "example remainder", longint'(remainder7), 64);
      end
      if (x == 2 ** (N7 - 2)) begin
        chk(root7 == 64 && remainder7 == 0, "R9", "lowest radicand root",
            longint'(root7), 64);
      end
      if (x == 2 ** N7 - 1) begin
        chk(root7 == 127, "R10", "highest radicand root", longint'(root7), 127);
        chk(remainder7 == 127, "R10", "highest radicand remainder",
            longint'(remainder7), 127);
      end
      @(negedge clk);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule